// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a CPU bus and a slow byte-wide main memory. It holds a small direct-mapped cache: one byte of data, one stored tag and one valid flag per line. It compares the incoming address against the addressed line to produce a hit. A four-state controller sequences every access. Reads that hit are answered straight from the cache. Read misses and all writes go to main memory, and the controller waits for the memory's ready pulse.

The policy is write-through with no fetch on a write miss. Every write updates main memory. The same write also overwrites the indexed cache line with the new byte and tag, whether or not it hit. A read miss fills the line with the byte returned by memory. The CPU holds its request until it sees the one-cycle acknowledge. Main memory shares the CPU address and write-data lines. It reports completion on `mem_ready`.

Controller states: IDLE (encoding 000), WRITE, RD_HIT and RD_MISS. The transitions are:
- IDLE→WRITE on a write request.
- IDLE→RD_HIT on a read request that hits.
- IDLE→RD_MISS on a read request that misses.
- WRITE→IDLE and RD_MISS→IDLE when `mem_ready` is seen.
- RD_HIT→IDLE unconditionally.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid and the controller is idle. No output strobe is active, `mem_rw_n` is 1, and the first read of any address misses.
- R2: The address splits into a line index (bits 3:0) and a tag (bits 7:4). `hit` is 1 only when the indexed line is valid and its stored tag equals address bits 7:4.
- R3: A read that hits is acknowledged in the first cycle after it is accepted. The cached byte is driven on `cpu_rdata` with `cache_drive_en` high, and no memory access is started.
- R4: A read miss starts memory with `mem_start`=1 and `mem_rw_n`=1, and `mem_drive_en` stays high while waiting. On `mem_ready` the byte and tag are written into the line. The acknowledge follows in the next cycle, with that byte on `cpu_rdata`.
- R5: Any write, hit or miss, starts memory with `mem_rw_n`=0, so memory receives the byte. On `mem_ready` the same byte and tag replace the indexed line without a fetch. The acknowledge follows in the next cycle.
- R6: `cpu_ack` is a single-cycle pulse. With a memory answering three cycles after the start edge, a miss or write completes five cycles after acceptance.
- R7: When read and write are requested together, the access is performed as a write.
- R8: A request is accepted only in IDLE and never in the acknowledge cycle. A request still held during `cpu_ack` starts nothing.
- R9: A line holds one tag at a time. A read of another address with the same index misses and replaces it, and the evicted address misses on its next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | CPU read request, held until acknowledge |
| cpu_wr | input | 1 | CPU write request, held until acknowledge |
| cpu_addr | input | 8 | CPU byte address, also seen by memory |
| cpu_wdata | input | 8 | CPU write byte, also seen by memory |
| cpu_rdata | output | 8 | Read byte returned to the CPU |
| cpu_ack | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Indexed line valid and tag equal |
| mem_start | output | 1 | Starts a memory access at the next edge |
| mem_rw_n | output | 1 | Memory direction, 0 = write |
| mem_rdata | input | 8 | Byte returned by memory |
| mem_ready | input | 1 | Memory access complete |
| mem_drive_en | output | 1 | Memory data is routed to the CPU bus |
| cache_drive_en | output | 1 | Cache data is routed to the CPU bus |
| cache_we | output | 1 | Shared data/tag line write strobe |

## Verification
The hardest situations to reach from the ports are line replacement and a request that is still held when the acknowledge arrives. Replacement means a write miss that silently replaces a line, and a read that evicts another tag at the same index. The vector table drives accesses that alias on index 3 in an order that forces eviction, write-miss allocation, and a later refetch. The refetch proves memory saw the earlier write. For every access the bench keeps the request asserted through the acknowledge cycle and checks that no new memory start appears. A second reset in mid-run confirms that previously cached lines are forgotten.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'b000,
        ST_WRITE   = 3'b001,
        ST_RD_HIT  = 3'b010,
        ST_RD_MISS = 3'b100
    } ctl_state_t;
endpackage

// File: rtl/cache_store.sv
module cache_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              hit
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] data_q [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DEPTH-1:0]  valid_q;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    assign idx = addr[IDX_W-1:0];
    assign tag = addr[ADDR_W-1:IDX_W];

    for (genvar i = 0; i < DEPTH; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                valid_q[i] <= 1'b0;
            else if (we && idx == IDX_W'(i))
                valid_q[i] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (we && idx == IDX_W'(i)) begin
                data_q[i] <= wdata;
                tag_q[i]  <= tag;
            end
        end
    end

    assign rdata = data_q[idx];
    assign hit   = valid_q[idx] && (tag_q[idx] == tag);
endmodule

// File: rtl/cache_fsm.sv
module cache_fsm
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic hit,
    input  logic mem_ready,
    output logic mem_start,
    output logic mem_rw_n,
    output logic mem_drive_en,
    output logic cache_drive_en,
    output logic line_we,
    output logic fill_sel,
    output logic cpu_ack
);
    ctl_state_t state_q, state_d;
    logic       done_q;
    logic       done_rd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b0;
            done_rd_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            done_q    <= (state_q == ST_WRITE || state_q == ST_RD_MISS) && mem_ready;
            done_rd_q <= (state_q == ST_RD_MISS) && mem_ready;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!done_q) begin
                    if (wr_req)
                        state_d = ST_WRITE;
                    else if (rd_req && hit)
                        state_d = ST_RD_HIT;
                    else if (rd_req)
                        state_d = ST_RD_MISS;
                end
            end
            ST_WRITE:   if (mem_ready) state_d = ST_IDLE;
            ST_RD_HIT:  state_d = ST_IDLE;
            ST_RD_MISS: if (mem_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_start      = 1'b0;
        mem_rw_n       = 1'b1;
        mem_drive_en   = 1'b0;
        line_we        = 1'b0;
        fill_sel       = 1'b0;
        cache_drive_en = done_rd_q;
        cpu_ack        = done_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!done_q && (wr_req || (rd_req && !hit))) begin
                    mem_start = 1'b1;
                    mem_rw_n  = !wr_req;
                end
            end
            ST_WRITE: begin
                mem_rw_n = 1'b0;
                line_we  = mem_ready;
            end
            ST_RD_HIT: begin
                cache_drive_en = 1'b1;
                cpu_ack        = 1'b1;
            end
            ST_RD_MISS: begin
                mem_drive_en = 1'b1;
                line_we      = mem_ready;
                fill_sel     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              hit,
    output logic              mem_start,
    output logic              mem_rw_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              mem_drive_en,
    output logic              cache_drive_en,
    output logic              cache_we
);
    logic [DATA_W-1:0] line_rdata;
    logic [DATA_W-1:0] line_wdata;
    logic              fill_sel;

    assign line_wdata = fill_sel ? mem_rdata : cpu_wdata;

    cache_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (cpu_addr),
        .we    (cache_we),
        .wdata (line_wdata),
        .rdata (line_rdata),
        .hit   (hit)
    );

    cache_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_req         (cpu_rd),
        .wr_req         (cpu_wr),
        .hit            (hit),
        .mem_ready      (mem_ready),
        .mem_start      (mem_start),
        .mem_rw_n       (mem_rw_n),
        .mem_drive_en   (mem_drive_en),
        .cache_drive_en (cache_drive_en),
        .line_we        (cache_we),
        .fill_sel       (fill_sel),
        .cpu_ack        (cpu_ack)
    );

    assign cpu_rdata = cache_drive_en ? line_rdata :
                       mem_drive_en   ? mem_rdata  : '0;
endmodule

// File: rtl/cache_chk.sv
module cache_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_ack,
    input logic mem_start,
    input logic mem_rw_n,
    input logic mem_ready,
    input logic mem_drive_en,
    input logic cache_drive_en,
    input logic cache_we
);
    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R3
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_drive_en |-> (!mem_start && !mem_drive_en));

    // R4
    miss_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && mem_drive_en) |=> (cpu_ack && cache_drive_en));

    // R5
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && !mem_rw_n) |=> cpu_ack);

    // R5
    line_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_we |-> mem_ready);

    // R8
    ack_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> !mem_start);

    // R3
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cache_drive_en, mem_drive_en}));
endmodule

bind dm_wt_cache cache_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_ack        (cpu_ack),
    .mem_start      (mem_start),
    .mem_rw_n       (mem_rw_n),
    .mem_ready      (mem_ready),
    .mem_drive_en   (mem_drive_en),
    .cache_drive_en (cache_drive_en),
    .cache_we       (cache_we)
);

// File: tb/sim_dm_wt_cache.sv
`timescale 1ns/1ps
module sim_dm_wt_cache;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic [7:0] cpu_rdata, mem_rdata;
    logic       cpu_ack, hit, mem_start, mem_rw_n, mem_ready;
    logic       mem_drive_en, cache_drive_en, cache_we;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dm_wt_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .hit(hit), .mem_start(mem_start), .mem_rw_n(mem_rw_n),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_drive_en(mem_drive_en),
        .cache_drive_en(cache_drive_en), .cache_we(cache_we)
    );

    // main memory model: ready pulses three edges after the start edge
    logic [7:0] mem [256];
    logic [7:0] lat_addr = '0;
    logic [1:0] lat_cnt = '0;
    logic       busy = 1'b0;
    logic       rdy_q = 1'b0;
    initial for (int a = 0; a < 256; a++) mem[a] = 8'(a) ^ 8'h5A;
    always @(posedge clk) begin
        rdy_q <= 1'b0;
        if (mem_start) begin
            lat_addr <= cpu_addr;
            if (!mem_rw_n) mem[cpu_addr] <= cpu_wdata;
            lat_cnt <= 2'd2;
            busy    <= 1'b1;
        end else if (busy) begin
            if (lat_cnt == 0) begin
                rdy_q <= 1'b1;
                busy  <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1'b1;
            end
        end
    end
    assign mem_ready = rdy_q;
    assign mem_rdata = mem[lat_addr];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // op: 1 = read, 2 = write, 3 = both
    // {op[1:0], addr[7:0], wdata[7:0], hit, data[7:0], cycles[3:0]}
    localparam int NV = 12;
    localparam logic [30:0] VEC [NV] = '{
        {2'd1, 8'h13, 8'h00, 1'b0, 8'h49, 4'd5},
        {2'd1, 8'h13, 8'h00, 1'b1, 8'h49, 4'd1},
        {2'd2, 8'h23, 8'hA1, 1'b0, 8'h00, 4'd5},
        {2'd1, 8'h23, 8'h00, 1'b1, 8'hA1, 4'd1},
        {2'd1, 8'h13, 8'h00, 1'b0, 8'h49, 4'd5},
        {2'd2, 8'h13, 8'h3C, 1'b1, 8'h00, 4'd5},
        {2'd1, 8'h13, 8'h00, 1'b1, 8'h3C, 4'd1},
        {2'd1, 8'hF3, 8'h00, 1'b0, 8'hA9, 4'd5},
        {2'd1, 8'h13, 8'h00, 1'b0, 8'h3C, 4'd5},
        {2'd3, 8'h40, 8'h77, 1'b0, 8'h00, 4'd5},
        {2'd1, 8'h40, 8'h00, 1'b1, 8'h77, 4'd1},
        {2'd1, 8'h0F, 8'h00, 1'b0, 8'h55, 4'd5}
    };

    task automatic access(input logic [1:0] op, input logic [7:0] addr, input logic [7:0] wd,
                          input logic exp_hit, input logic [7:0] exp_data, input int exp_cyc);
        int  n = 0;
        bit  is_wr = op[1];
        @(negedge clk);
        cpu_addr = addr; cpu_wdata = wd; cpu_rd = op[0]; cpu_wr = op[1];
        #1;
        check("R2 hit flag", int'(hit), int'(exp_hit));
        check((is_wr || !exp_hit) ? "R4/R5 memory start" : "R3 no memory start",
              int'(mem_start), int'(is_wr || !exp_hit));
        if (mem_start) check(is_wr ? "R5/R7 write direction" : "R4 read direction",
                             int'(mem_rw_n), int'(!is_wr));
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ack && n < 40);
        check("R6 completion cycles", n, exp_cyc);
        check("R8 no start in ack cycle", int'(mem_start), 0);
        if (!is_wr) check(exp_hit ? "R3 hit data" : "R4/R9 miss data", int'(cpu_rdata), int'(exp_data));
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
        check("R6 ack single cycle", int'(cpu_ack), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ack idle", int'(cpu_ack), 0);
        check("R1 mem_start idle", int'(mem_start), 0);
        check("R1 rw idle", int'(mem_rw_n), 1);
        check("R1 drivers idle", int'({cache_drive_en, mem_drive_en, cache_we}), 0);
        check("R1 R2 invalid line at tag 0", int'(hit), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++)
            access(VEC[i][30:29], VEC[i][28:21], VEC[i][20:13], VEC[i][12], VEC[i][11:4], int'(VEC[i][3:0]));
        // R1: mid-run reset forgets cached lines
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(2'd1, 8'h40, 8'h00, 1'b0, 8'h77, 5);
        access(2'd1, 8'h40, 8'h00, 1'b1, 8'h77, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule